// File: doc/BRIEF.md
# I2S Sample Word Packer

This block stands between a 16-bit data register port and the serial shifter of an I2S-style audio interface. On the transmit side it collects one or two 16-bit register words per audio channel, places them into a 16-bit or 32-bit channel slot with the zero padding that the chosen alignment standard and data width require, and shifts the slot out most significant bit first. On the receive side it samples incoming serial bits, and at the end of the slot it splits them back into 16-bit register words. Any padding position reads back as zero.

Four alignment standards are accepted: Philips, PCM, MSB-justified and LSB-justified. Sample widths are 16, 24 or 32 bits, and slot widths are 16 or 32 bits. The block also reports how many 16-bit register accesses each channel needs, so that DMA logic can pace its transfers. A configuration with no defined layout is flagged as an error, and the shifter then sends only zeros. Serial clock generation and word-select timing are supplied from outside through a slot-start strobe and a bit-enable strobe.

Top module: `i2s_word_packer`

## Requirements
- R1: Encodings are: `fmt_std` 0 Philips, 1 PCM, 2 MSB-justified, 3 LSB-justified; `smp_len` 0 = 16 bit, 1 = 24 bit, 2 = 32 bit, 3 reserved; `slot_len` 0 = 16-bit slot, 1 = 32-bit slot. `acc_cnt` is 1 for 16-bit samples (either slot width) and 2 for 24-bit or 32-bit samples in a 32-bit slot. It is 0, with `cfg_err` high, for a reserved sample length or for a 24-bit or 32-bit sample in a 16-bit slot.
- R2: With a 16-bit sample in a 16-bit slot, under any standard, the 16 slot bits are the first written word.
- R3: With a 16-bit sample in a 32-bit slot under Philips, PCM or MSB-justified, the slot is {word0, 16 zero bits}.
- R4: With a 16-bit sample in a 32-bit slot under LSB-justified, the slot is {16 zero bits, word0}.
- R5: With a 24-bit sample under Philips, PCM or MSB-justified, the slot is {word0, word1[15:8], 8 zero bits}.
- R6: With a 24-bit sample under LSB-justified, the slot is {8 zero bits, word0[7:0], word1}.
- R7: With a 32-bit sample, under any standard, the slot is {word0, word1}.
- R8: A write-index counter returns to zero on `slot_start`. The first accepted write fills word0 and the second fills word1. Writes beyond `acc_cnt`, or made in a `slot_start` cycle, are ignored. `tx_req` is high exactly while fewer than `acc_cnt` words have been accepted.
- R9: After the last bit of a slot (16 or 32 `bit_en` strobes after `slot_start`), `rx_done` is high for exactly one cycle, and `rx_word0`/`rx_word1` hold the received slot split by the inverse of R2 to R7. Padding bits read as zero whatever their values on the line, an unused second word reads as zero, and extra `bit_en` strobes do not raise `rx_done` again.
- R10: Under a configuration error, a slot loaded at `slot_start` shifts out only zeros and `rx_done` stays low.
- R11: After reset, `ser_out`, `rx_done`, `rx_word0` and `rx_word1` are zero and the write index is zero.
- R12: The cycle after `slot_start`, `ser_out` shows slot bit 31. Each `bit_en` moves on to the next lower bit. When `slot_start` and `bit_en` are high together, `slot_start` wins and no shift occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fmt_std | input | 2 | Alignment standard select |
| smp_len | input | 2 | Sample width select |
| slot_len | input | 1 | Slot width select |
| cfg_err | output | 1 | Configuration has no defined layout |
| acc_cnt | output | 2 | 16-bit register accesses per channel |
| tx_wr | input | 1 | Register word write strobe |
| tx_word | input | 16 | Register word to transmit |
| tx_req | output | 1 | More words wanted for the next slot |
| slot_start | input | 1 | Start of a new channel slot |
| bit_en | input | 1 | Serial bit strobe |
| ser_out | output | 1 | Serial transmit bit |
| ser_in | input | 1 | Serial receive bit |
| rx_done | output | 1 | Received slot unpacked, one-cycle pulse |
| rx_word0 | output | 16 | First received register word |
| rx_word1 | output | 16 | Second received register word |

## Verification
The assertions watch, on every cycle, the link between the error flag and the access count. They also check that a slot loaded under an error drives zeros, that `rx_done` is a single-cycle pulse following a bit strobe and never follows an erroneous configuration, that a 16-bit sample never yields a non-zero second received word, and that the write request reopens after each slot start. The exact bit placement and zero fill of each standard and width combination, the refusal of surplus writes, and the zeroing of padding driven high on the line can be shown only by the bench's scenarios. So can the precedence of slot start over a bit strobe. The bench covers this with loopback slots and with forced serial input.

// File: rtl/i2spk_pkg.sv
package i2spk_pkg;

   typedef enum logic [1:0] {
      STD_PHILIPS = 2'd0,
      STD_PCM     = 2'd1,
      STD_MSBJ    = 2'd2,
      STD_LSBJ    = 2'd3
   } std_e;

   typedef enum logic [1:0] {
      SMP_16  = 2'd0,
      SMP_24  = 2'd1,
      SMP_32  = 2'd2,
      SMP_RSV = 2'd3
   } smp_e;

   // Slot layouts: where the words sit inside the slot
   typedef enum logic [2:0] {
      LAY_SHORT = 3'd0,  // 16-bit slot, one word
      LAY_HI16  = 3'd1,  // 32-bit slot, word in upper half
      LAY_LO16  = 3'd2,  // 32-bit slot, word in lower half
      LAY_HI24  = 3'd3,  // 24 bits, left justified
      LAY_LO24  = 3'd4,  // 24 bits, right justified
      LAY_FULL  = 3'd5,  // 32 bits, two words
      LAY_BAD   = 3'd6   // no defined layout
   } layout_e;

endpackage

// File: rtl/i2spk_cfg_dec.sv
module i2spk_cfg_dec
   import i2spk_pkg::*;
(
   input  logic [1:0] fmt_std,
   input  logic [1:0] smp_len,
   input  logic       slot_len,
   output layout_e    layout,
   output logic [1:0] acc_cnt,
   output logic       cfg_err
);

   logic is_lsbj;
   assign is_lsbj = (fmt_std == STD_LSBJ);

   always_comb begin
      layout = LAY_BAD;
      if (!slot_len) begin
         if (smp_len == SMP_16) layout = LAY_SHORT;
      end else begin
         case (smp_len)
            SMP_16:  layout = is_lsbj ? LAY_LO16 : LAY_HI16;
            SMP_24:  layout = is_lsbj ? LAY_LO24 : LAY_HI24;
            SMP_32:  layout = LAY_FULL;
            default: layout = LAY_BAD;
         endcase
      end
   end

   always_comb begin
      case (layout)
         LAY_SHORT, LAY_HI16, LAY_LO16: acc_cnt = 2'd1;
         LAY_HI24, LAY_LO24, LAY_FULL:  acc_cnt = 2'd2;
         default:                       acc_cnt = 2'd0;
      endcase
   end

   assign cfg_err = (layout == LAY_BAD);

endmodule

// File: rtl/i2spk_tx.sv
module i2spk_tx
   import i2spk_pkg::*;
#(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  layout_e           layout,
   input  logic [1:0]        acc_cnt,
   input  logic              slot_start,
   input  logic              bit_en,
   input  logic              wr,
   input  logic [WORD_W-1:0] wdata,
   output logic              req,
   output logic              ser_out
);

   localparam int SLOT_W = 2 * WORD_W;
   localparam int HALF_W = WORD_W / 2;

   logic [WORD_W-1:0] stage0, stage1;
   logic [1:0]        widx;
   logic [SLOT_W-1:0] slot_img, shreg;
   logic              wr_ok;

   assign req   = (widx < acc_cnt);
   assign wr_ok = wr && !slot_start && req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         widx   <= '0;
         stage0 <= '0;
         stage1 <= '0;
      end else if (slot_start) begin
         widx <= '0;
      end else if (wr_ok) begin
         widx <= widx + 2'd1;
         if (widx == 2'd0) stage0 <= wdata;
         else              stage1 <= wdata;
      end
   end

   always_comb begin
      case (layout)
         LAY_SHORT: slot_img = {stage0, {WORD_W{1'b0}}};
         LAY_HI16:  slot_img = {stage0, {WORD_W{1'b0}}};
         LAY_LO16:  slot_img = {{WORD_W{1'b0}}, stage0};
         LAY_HI24:  slot_img = {stage0, stage1[WORD_W-1:HALF_W], {HALF_W{1'b0}}};
         LAY_LO24:  slot_img = {{HALF_W{1'b0}}, stage0[HALF_W-1:0], stage1};
         LAY_FULL:  slot_img = {stage0, stage1};
         default:   slot_img = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          shreg <= '0;
      else if (slot_start) shreg <= slot_img;
      else if (bit_en)     shreg <= {shreg[SLOT_W-2:0], 1'b0};
   end

   assign ser_out = shreg[SLOT_W-1];

endmodule

// File: rtl/i2spk_rx.sv
module i2spk_rx
   import i2spk_pkg::*;
#(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  layout_e           layout,
   input  logic              slot_start,
   input  logic              bit_en,
   input  logic              ser_in,
   output logic              done,
   output logic [WORD_W-1:0] word0,
   output logic [WORD_W-1:0] word1
);

   localparam int SLOT_W = 2 * WORD_W;
   localparam int HALF_W = WORD_W / 2;
   localparam int CNT_W  = $clog2(SLOT_W + 1);

   logic [SLOT_W-1:0] cap, cap_nx;
   logic [CNT_W-1:0]  bcnt, nbits;
   logic [WORD_W-1:0] hi, lo, u0, u1;
   logic              last_bit;

   assign nbits    = (layout == LAY_SHORT) ? CNT_W'(WORD_W) : CNT_W'(SLOT_W);
   assign cap_nx   = {cap[SLOT_W-2:0], ser_in};
   assign hi       = cap_nx[SLOT_W-1:WORD_W];
   assign lo       = cap_nx[WORD_W-1:0];
   assign last_bit = bit_en && !slot_start && (bcnt == nbits - CNT_W'(1));

   always_comb begin
      u0 = '0;
      u1 = '0;
      case (layout)
         LAY_SHORT, LAY_LO16: u0 = lo;
         LAY_HI16:            u0 = hi;
         LAY_HI24: begin
            u0 = hi;
            u1 = {lo[WORD_W-1:HALF_W], {HALF_W{1'b0}}};
         end
         LAY_LO24: begin
            u0 = {{HALF_W{1'b0}}, hi[HALF_W-1:0]};
            u1 = lo;
         end
         LAY_FULL: begin
            u0 = hi;
            u1 = lo;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap  <= '0;
         bcnt <= '0;
      end else if (slot_start) begin
         bcnt <= '0;
      end else if (bit_en && bcnt < nbits) begin
         cap  <= cap_nx;
         bcnt <= bcnt + CNT_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done  <= 1'b0;
         word0 <= '0;
         word1 <= '0;
      end else begin
         done <= 1'b0;
         if (last_bit && layout != LAY_BAD) begin
            done  <= 1'b1;
            word0 <= u0;
            word1 <= u1;
         end
      end
   end

endmodule

// File: rtl/i2s_word_packer.sv
module i2s_word_packer
   import i2spk_pkg::*;
#(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        fmt_std,
   input  logic [1:0]        smp_len,
   input  logic              slot_len,
   output logic              cfg_err,
   output logic [1:0]        acc_cnt,
   input  logic              tx_wr,
   input  logic [WORD_W-1:0] tx_word,
   output logic              tx_req,
   input  logic              slot_start,
   input  logic              bit_en,
   output logic              ser_out,
   input  logic              ser_in,
   output logic              rx_done,
   output logic [WORD_W-1:0] rx_word0,
   output logic [WORD_W-1:0] rx_word1
);

   generate
      if (WORD_W < 4 || (WORD_W % 2) != 0) begin : g_bad_width
         $error("i2s_word_packer: WORD_W must be even and at least 4");
      end
   endgenerate

   layout_e layout;

   i2spk_cfg_dec dec_i (
      .fmt_std (fmt_std),
      .smp_len (smp_len),
      .slot_len(slot_len),
      .layout  (layout),
      .acc_cnt (acc_cnt),
      .cfg_err (cfg_err)
   );

   i2spk_tx #(.WORD_W(WORD_W)) tx_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .layout    (layout),
      .acc_cnt   (acc_cnt),
      .slot_start(slot_start),
      .bit_en    (bit_en),
      .wr        (tx_wr),
      .wdata     (tx_word),
      .req       (tx_req),
      .ser_out   (ser_out)
   );

   i2spk_rx #(.WORD_W(WORD_W)) rx_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .layout    (layout),
      .slot_start(slot_start),
      .bit_en    (bit_en),
      .ser_in    (ser_in),
      .done      (rx_done),
      .word0     (rx_word0),
      .word1     (rx_word1)
   );

endmodule

// File: rtl/i2s_word_packer_chk.sv
module i2s_word_packer_chk #(
   parameter int WORD_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        fmt_std,
   input logic [1:0]        smp_len,
   input logic              slot_len,
   input logic              cfg_err,
   input logic [1:0]        acc_cnt,
   input logic              tx_req,
   input logic              slot_start,
   input logic              bit_en,
   input logic              ser_out,
   input logic              rx_done,
   input logic [WORD_W-1:0] rx_word1
);

   assert_err_no_access_R1: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> acc_cnt == 2'd0);

   assert_valid_access_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_err |-> (acc_cnt == 2'd1 || acc_cnt == 2'd2));

   assert_req_reopens_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_start && !cfg_err) ##1 $stable({fmt_std, smp_len, slot_len}) |-> tx_req);

   assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done |=> !rx_done);

   assert_done_after_bit_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done |-> $past(bit_en));

   assert_short_word1_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_done && $past(smp_len) == 2'd0) |-> rx_word1 == '0);

   assert_err_no_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done |-> !$past(cfg_err));

   assert_err_zero_out_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_start && cfg_err) |=> !ser_out);

endmodule

bind i2s_word_packer i2s_word_packer_chk #(.WORD_W(WORD_W)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .fmt_std   (fmt_std),
   .smp_len   (smp_len),
   .slot_len  (slot_len),
   .cfg_err   (cfg_err),
   .acc_cnt   (acc_cnt),
   .tx_req    (tx_req),
   .slot_start(slot_start),
   .bit_en    (bit_en),
   .ser_out   (ser_out),
   .rx_done   (rx_done),
   .rx_word1  (rx_word1)
);

// File: tb/i2s_word_packer_tb_top.sv
module i2s_word_packer_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  fmt_std = 2'd0;
   logic [1:0]  smp_len = 2'd0;
   logic        slot_len = 1'b0;
   logic        cfg_err;
   logic [1:0]  acc_cnt;
   logic        tx_wr = 1'b0;
   logic [15:0] tx_word = '0;
   logic        tx_req;
   logic        slot_start = 1'b0;
   logic        bit_en = 1'b0;
   logic        ser_out;
   logic        ser_in;
   logic        rx_done;
   logic [15:0] rx_word0, rx_word1;
   logic        lb_en = 1'b1;
   logic        ser_force = 1'b0;

   int total = 0;
   int bad = 0;

   always #5 clk = ~clk;

   assign ser_in = lb_en ? ser_out : ser_force;

   i2s_word_packer dut_i (
      .clk(clk), .rst_n(rst_n), .fmt_std(fmt_std), .smp_len(smp_len),
      .slot_len(slot_len), .cfg_err(cfg_err), .acc_cnt(acc_cnt),
      .tx_wr(tx_wr), .tx_word(tx_word), .tx_req(tx_req),
      .slot_start(slot_start), .bit_en(bit_en), .ser_out(ser_out),
      .ser_in(ser_in), .rx_done(rx_done), .rx_word0(rx_word0),
      .rx_word1(rx_word1)
   );

   typedef struct packed {
      logic [1:0]  std;
      logic [1:0]  smp;
      logic        slot;
      logic [15:0] w0;
      logic [15:0] w1;
      logic [1:0]  acc;
      logic [31:0] img;
      logic [15:0] r0;
      logic [15:0] r1;
      logic [3:0]  req;
   } vec_t;

   // Rows tagged R2, R2, R3, R4, R5, R6, R7, R7, R5, R10, R10
   localparam int NVEC = 11;
   localparam vec_t VECS [NVEC] = '{
      '{2'd0, 2'd0, 1'b0, 16'h9AB4, 16'h3C7E, 2'd1, 32'h9AB4_0000, 16'h9AB4, 16'h0000, 4'd2},
      '{2'd3, 2'd0, 1'b0, 16'h9AB4, 16'h3C7E, 2'd1, 32'h9AB4_0000, 16'h9AB4, 16'h0000, 4'd2},
      '{2'd1, 2'd0, 1'b1, 16'h9AB4, 16'h3C7E, 2'd1, 32'h9AB4_0000, 16'h9AB4, 16'h0000, 4'd3},
      '{2'd3, 2'd0, 1'b1, 16'h9AB4, 16'h3C7E, 2'd1, 32'h0000_9AB4, 16'h9AB4, 16'h0000, 4'd4},
      '{2'd2, 2'd1, 1'b1, 16'h9AB4, 16'h3C7E, 2'd2, 32'h9AB4_3C00, 16'h9AB4, 16'h3C00, 4'd5},
      '{2'd3, 2'd1, 1'b1, 16'h9AB4, 16'h3C7E, 2'd2, 32'h00B4_3C7E, 16'h00B4, 16'h3C7E, 4'd6},
      '{2'd0, 2'd2, 1'b1, 16'h9AB4, 16'h3C7E, 2'd2, 32'h9AB4_3C7E, 16'h9AB4, 16'h3C7E, 4'd7},
      '{2'd3, 2'd2, 1'b1, 16'hF00F, 16'h1234, 2'd2, 32'hF00F_1234, 16'hF00F, 16'h1234, 4'd7},
      '{2'd1, 2'd1, 1'b1, 16'hFFFF, 16'hFFFF, 2'd2, 32'hFFFF_FF00, 16'hFFFF, 16'hFF00, 4'd5},
      '{2'd0, 2'd1, 1'b0, 16'h9AB4, 16'h3C7E, 2'd0, 32'h0000_0000, 16'h0000, 16'h0000, 4'd10},
      '{2'd2, 2'd3, 1'b1, 16'h9AB4, 16'h3C7E, 2'd0, 32'h0000_0000, 16'h0000, 16'h0000, 4'd10}
   };

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic pulse_start();
      @(negedge clk); slot_start = 1'b1;
      @(negedge clk); slot_start = 1'b0;
   endtask

   task automatic put_word(input logic [15:0] w);
      @(negedge clk); tx_wr = 1'b1; tx_word = w;
      @(negedge clk); tx_wr = 1'b0;
   endtask

   task automatic set_cfg(input logic [1:0] s, input logic [1:0] d, input logic c);
      @(negedge clk); fmt_std = s; smp_len = d; slot_len = c;
   endtask

   // Shift nb bits; returns captured serial output, left aligned
   task automatic shift_slot(input int nb, output logic [31:0] got);
      got = '0;
      for (int i = 0; i < nb; i++) begin
         got[31-i] = ser_out;
         bit_en = 1'b1;
         @(negedge clk);
      end
      bit_en = 1'b0;
   endtask

   task automatic run_vec(input vec_t v);
      logic [31:0] got, mask;
      int nb;
      string rt;
      rt = $sformatf("R%0d", v.req);
      set_cfg(v.std, v.smp, v.slot);
      #1;
      check(acc_cnt == v.acc && cfg_err == (v.acc == 2'd0), "R1 acc_cnt/cfg_err",
            {29'd0, cfg_err, acc_cnt}, {29'd0, v.acc == 2'd0, v.acc});
      pulse_start();
      check(tx_req == (v.acc != 2'd0), "R8 tx_req after slot_start", tx_req, v.acc != 2'd0);
      put_word(v.w0);
      put_word(v.w1);
      put_word(16'hDEAD);
      check(tx_req == 1'b0, "R8 tx_req after writes", tx_req, 0);
      pulse_start();
      nb = v.slot ? 32 : 16;
      mask = v.slot ? 32'hFFFF_FFFF : 32'hFFFF_0000;
      shift_slot(nb, got);
      check((got & mask) == (v.img & mask), {rt, " slot bits"}, got & mask, v.img & mask);
      if (v.acc != 2'd0) begin
         check(rx_done && rx_word0 == v.r0 && rx_word1 == v.r1, "R9 loopback words",
               {rx_word0, rx_word1}, {v.r0, v.r1});
         @(negedge clk);
         check(!rx_done, "R9 rx_done one cycle", rx_done, 0);
      end else begin
         check(!rx_done, "R10 no rx_done on error", rx_done, 0);
      end
   endtask

   task automatic rx_forced(input logic [1:0] s, input logic [1:0] d, input logic c,
                            input logic [15:0] e0, input logic [15:0] e1);
      logic [31:0] dummy;
      set_cfg(s, d, c);
      lb_en = 1'b0; ser_force = 1'b1;
      pulse_start();
      shift_slot(c ? 32 : 16, dummy);
      check(rx_done && rx_word0 == e0 && rx_word1 == e1, "R9 padding reads zero",
            {rx_word0, rx_word1}, {e0, e1});
      lb_en = 1'b1; ser_force = 1'b0;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      logic [31:0] dummy;
      repeat (3) @(negedge clk);
      // R11: reset state
      check(ser_out == 1'b0 && rx_done == 1'b0 && rx_word0 == '0 && rx_word1 == '0,
            "R11 outputs in reset", {ser_out, rx_done, rx_word0[7:0]}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(tx_req == 1'b1, "R11 write index zero after reset", tx_req, 1);

      for (int k = 0; k < NVEC; k++) run_vec(VECS[k]);

      // R9: padding driven high on the line is dropped
      rx_forced(2'd2, 2'd1, 1'b1, 16'hFFFF, 16'hFF00);
      rx_forced(2'd3, 2'd1, 1'b1, 16'h00FF, 16'hFFFF);
      rx_forced(2'd0, 2'd0, 1'b1, 16'hFFFF, 16'h0000);
      rx_forced(2'd3, 2'd0, 1'b0, 16'hFFFF, 16'h0000);

      // R9: extra bit strobes after slot end raise nothing
      @(negedge clk); bit_en = 1'b1;
      repeat (3) begin
         @(negedge clk);
         check(!rx_done, "R9 no done on extra bits", rx_done, 0);
      end
      bit_en = 1'b0;

      // R12: slot_start wins over bit_en; then one shift
      set_cfg(2'd0, 2'd2, 1'b1);
      pulse_start();
      put_word(16'h8000);
      put_word(16'h0001);
      @(negedge clk); slot_start = 1'b1; bit_en = 1'b1;
      @(negedge clk); slot_start = 1'b0; bit_en = 1'b0;
      check(ser_out == 1'b1, "R12 load wins over shift", ser_out, 1);
      bit_en = 1'b1;
      @(negedge clk); bit_en = 1'b0;
      check(ser_out == 1'b0, "R12 next bit after strobe", ser_out, 0);

      // R8: a write in the slot_start cycle is dropped
      set_cfg(2'd0, 2'd0, 1'b0);
      pulse_start();
      put_word(16'h1111);
      @(negedge clk); slot_start = 1'b1; tx_wr = 1'b1; tx_word = 16'h7777;
      @(negedge clk); slot_start = 1'b0; tx_wr = 1'b0;
      check(tx_req == 1'b1, "R8 write with slot_start ignored", tx_req, 1);
      shift_slot(16, dummy);
      check(dummy[31:16] == 16'h1111, "R8 staged word kept", dummy[31:16], 16'h1111);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule